// File: doc/BRIEF.md
# Output Virtual Channel Allocator

This block hands out virtual channels (VCs) of the downstream routers to packets in a five-port wormhole router. Each port carries four VCs, so twenty input VCs can compete. When an input VC holds a header flit whose output port is already known, it raises a request naming that port. The allocator picks one requester per output port and gives it the lowest-numbered VC of that port that is not reserved. The grant appears combinationally in the same cycle as the request. The granted input VC then goes on to switch allocation. Body and tail flits follow on the VC their header received and never come back here.

An output VC stays reserved for the whole packet. It is returned only when two things have both happened: the owning input VC reports that its tail flit has left, and the downstream router reports that the VC is released. These two events may arrive in either order.

Top module: `vc_allocator`

## Requirements
- R1: After reset every output VC is free, no grant is asserted without a request, and the first request to any port is granted VC 0.
- R2: A grant carries on `grantVc` the lowest-numbered free VC of the requested port, and that VC becomes reserved from the next cycle.
- R3: Each output port grants at most one requester per cycle. Different ports grant independently in the same cycle.
- R4: Within one port the arbitration is round-robin over the input-VC indices 0..19. After a winner w, the search for the next winner starts at w+1 and wraps from 19 to 0.
- R5: A port whose four VCs are all reserved grants nothing. Its requesters stay pending and are granted once a VC of that port is freed.
- R6: A reserved VC is freed only after both the holder's tail-departure strobe and the downstream release strobe (`vcRelease` bit port*4+vc) have been seen, in either order.
- R7: An input VC that holds a VC and whose tail has not yet departed is not granted again, even if its request stays asserted. It may be granted again from the cycle after its tail strobe.
- R8: A request whose port code is 5, 6 or 7 is ignored and reserves no VC.
- R9: A release strobe for a VC that is not reserved, and a tail strobe from an input VC that holds nothing, have no effect.
- R10: A grant is a combinational response in the cycle of the request. A release takes effect for grants one cycle after the clock edge that completes it.
- R11: No output VC is ever granted while it is still reserved, so no VC is held by two packets at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 20 | Header request, one bit per input VC |
| reqPort | input | 60 | Requested output port, 3 bits per input VC (input VC i in bits 3i+2..3i) |
| tailDone | input | 20 | Tail of the packet held by an input VC has departed (one-cycle strobe) |
| vcRelease | input | 20 | Downstream VC released, bit port*4+vc (one-cycle strobe) |
| grantValid | output | 20 | Grant to each input VC |
| grantVc | output | 40 | Assigned output VC number, 2 bits per input VC |

## Verification
The hardest state to reach from the ports is a port with all four VCs reserved while a further header waits. In that state the arbiter has to keep the request pending through a tail strobe that arrives alone. It may release the waiting header only one cycle after the matching release strobe. The bench walks each of the five ports into this state in turn, using requesters spread across the index range. It drives the two release conditions in both orders. A long run with all twenty requesters on one port, each recycling its VC the cycle after its grant, checks the rotating winner order and the alternating VC numbers against values computed in the bench.

// File: rtl/vca_pkg.sv
package vca_pkg;
  parameter int NPORT = 5;
  parameter int NVC   = 4;
  localparam int NIN  = NPORT * NVC;
  localparam int NOVC = NPORT * NVC;
  localparam int PW   = $clog2(NPORT);
  localparam int VW   = $clog2(NVC);
  localparam int IW   = $clog2(NIN);

  // Strobes from the arbitration control into the state datapath
  typedef struct packed {
    logic [NPORT-1:0]         hit;
    logic [NPORT-1:0][IW-1:0] who;
    logic [NPORT-1:0][VW-1:0] vc;
  } vcaStrobe_t;
endpackage

// File: rtl/vca_arb_ctrl.sv
module vca_arb_ctrl
  import vca_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NIN-1:0]          reqValid,
  input  logic [NIN-1:0][PW-1:0]  reqPort,
  input  logic [NIN-1:0]          holding,
  input  logic [NOVC-1:0]         busy,
  output vcaStrobe_t              strobe
);
  logic [NPORT-1:0]         hitV;
  logic [NPORT-1:0][IW-1:0] whoV;
  logic [NPORT-1:0][VW-1:0] vcV;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [NIN-1:0] cand;
    logic [IW-1:0]  ptr;
    logic [IW-1:0]  win;
    logic           found;
    logic [VW-1:0]  freeVc;
    logic           anyFree;

    always_comb begin
      for (int i = 0; i < NIN; i++)
        cand[i] = reqValid[i] && !holding[i] && (reqPort[i] == PW'(p));
    end

    // rotating search starting at the pointer
    always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 0; k < NIN; k++) begin
        int idx;
        idx = (int'(ptr) + k) % NIN;
        if (!found && cand[idx]) begin
          found = 1'b1;
          win   = IW'(idx);
        end
      end
    end

    // lowest-numbered free VC of this port
    always_comb begin
      anyFree = 1'b0;
      freeVc  = '0;
      for (int v = NVC - 1; v >= 0; v--) begin
        if (!busy[p*NVC + v]) begin
          anyFree = 1'b1;
          freeVc  = VW'(v);
        end
      end
    end

    assign hitV[p] = found && anyFree;
    assign whoV[p] = win;
    assign vcV[p]  = freeVc;

    always_ff @(posedge clk) begin
      if (!rstN)
        ptr <= '0;
      else if (hitV[p])
        ptr <= (win == IW'(NIN - 1)) ? '0 : win + IW'(1);
    end
  end

  always_comb begin
    strobe.hit = hitV;
    strobe.who = whoV;
    strobe.vc  = vcV;
  end
endmodule

// File: rtl/vca_state_dp.sv
module vca_state_dp
  import vca_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  vcaStrobe_t             strobe,
  input  logic [NIN-1:0]         tailDone,
  input  logic [NOVC-1:0]        vcRelease,
  output logic [NIN-1:0]         grantValid,
  output logic [NIN-1:0][VW-1:0] grantVc,
  output logic [NIN-1:0]         holding,
  output logic [NOVC-1:0]        busy
);
  logic [NOVC-1:0]        tailSeen, relSeen;
  logic [NIN-1:0][PW-1:0] hPort;
  logic [NIN-1:0][VW-1:0] hVc;
  logic [NOVC-1:0]        tailNow, tailAll, relAll, clearV, setV;

  // grants fan back out to the requesters
  always_comb begin
    grantValid = '0;
    grantVc    = '0;
    for (int i = 0; i < NIN; i++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (strobe.hit[p] && strobe.who[p] == IW'(i)) begin
          grantValid[i] = 1'b1;
          grantVc[i]    = strobe.vc[p];
        end
      end
    end
  end

  // tail strobes map to the VC the input holds
  always_comb begin
    tailNow = '0;
    for (int i = 0; i < NIN; i++)
      if (tailDone[i] && holding[i])
        tailNow[int'(hPort[i])*NVC + int'(hVc[i])] = 1'b1;
  end

  always_comb begin
    setV = '0;
    for (int p = 0; p < NPORT; p++)
      if (strobe.hit[p])
        setV[p*NVC + int'(strobe.vc[p])] = 1'b1;
  end

  assign tailAll = (tailSeen | tailNow) & busy;
  assign relAll  = (relSeen | vcRelease) & busy;
  assign clearV  = tailAll & relAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= '0;
      tailSeen <= '0;
      relSeen  <= '0;
    end else begin
      busy     <= (busy & ~clearV) | setV;
      tailSeen <= tailAll & ~clearV;
      relSeen  <= relAll & ~clearV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holding <= '0;
      hPort   <= '0;
      hVc     <= '0;
    end else begin
      holding <= (holding & ~tailDone) | grantValid;
      for (int p = 0; p < NPORT; p++) begin
        if (strobe.hit[p]) begin
          hPort[strobe.who[p]] <= PW'(p);
          hVc[strobe.who[p]]   <= strobe.vc[p];
        end
      end
    end
  end
endmodule

// File: rtl/vc_allocator.sv
module vc_allocator
  import vca_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NIN-1:0]     reqValid,
  input  logic [NIN*PW-1:0]  reqPort,
  input  logic [NIN-1:0]     tailDone,
  input  logic [NOVC-1:0]    vcRelease,
  output logic [NIN-1:0]     grantValid,
  output logic [NIN*VW-1:0]  grantVc
);
  logic [NIN-1:0][PW-1:0] reqPortA;
  logic [NIN-1:0][VW-1:0] grantVcA;
  logic [NIN-1:0]         holdingV;
  logic [NOVC-1:0]        busyV;
  vcaStrobe_t             strobe;

  assign reqPortA = reqPort;
  assign grantVc  = grantVcA;

  vca_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPortA),
    .holding(holdingV), .busy(busyV), .strobe(strobe)
  );

  vca_state_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tailDone(tailDone),
    .vcRelease(vcRelease), .grantValid(grantValid), .grantVc(grantVcA),
    .holding(holdingV), .busy(busyV)
  );
endmodule

// File: rtl/vca_checker.sv
module vca_checker
  import vca_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NIN-1:0]    reqValid,
  input logic [NIN*PW-1:0] reqPort,
  input logic [NIN-1:0]    grantValid,
  input logic [NIN*VW-1:0] grantVc,
  input logic [NOVC-1:0]   busy
);
  logic [NPORT-1:0][NIN-1:0] portGrants;
  logic [NIN-1:0]            tgtBusy;

  always_comb begin
    portGrants = '0;
    tgtBusy    = '0;
    for (int i = 0; i < NIN; i++) begin
      for (int p = 0; p < NPORT; p++)
        if (grantValid[i] && reqPort[i*PW +: PW] == PW'(p))
          portGrants[p][i] = 1'b1;
      if (int'(reqPort[i*PW +: PW]) < NPORT)
        tgtBusy[i] = busy[int'(reqPort[i*PW +: PW])*NVC + int'(grantVc[i*VW +: VW])];
    end
  end

  for (genvar i = 0; i < NIN; i++) begin : g_in
    p_req_backs_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> reqValid[i]);
    p_port_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> (int'(reqPort[i*PW +: PW]) < NPORT));
    p_no_regrant_r7: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |=> !grantValid[i]);
    p_vc_free_r11: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> !tgtBusy[i]);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
      $countones(portGrants[p]) <= 1);
    p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
      (&busy[p*NVC +: NVC]) |-> (portGrants[p] == '0));
  end
endmodule

bind vc_allocator vca_checker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
  .grantValid(grantValid), .grantVc(grantVc), .busy(busyV)
);

// File: tb/vc_allocator_tb_top.sv
module vc_allocator_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [19:0] reqValid;
  logic [59:0] reqPort;
  logic [19:0] tailDone;
  logic [19:0] vcRelease;
  logic [19:0] grantValid;
  logic [39:0] grantVc;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vc_allocator dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .tailDone(tailDone), .vcRelease(vcRelease),
    .grantValid(grantValid), .grantVc(grantVc)
  );

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic setReq(input int i, input int p);
    reqValid[i] = 1'b1;
    reqPort[i*3 +: 3] = 3'(p);
  endtask

  task automatic dropReq(input int i);
    reqValid[i] = 1'b0;
  endtask

  task automatic chkVc(input string tag, input int idx, input int vc);
    checks++;
    if (grantVc[idx*2 +: 2] !== 2'(vc)) begin
      errors++;
      $display("FAIL %s: grantVc[%0d]=%0d expected %0d", tag, idx, grantVc[idx*2 +: 2], vc);
    end
  endtask

  // check grants before the edge, then advance one cycle and clear strobes
  task automatic cyc(input string tag, input logic [19:0] ev, input int idx, input int vc);
    @(negedge clk);
    checks++;
    if (grantValid !== ev) begin
      errors++;
      $display("FAIL %s: grantValid=%h expected %h", tag, grantValid, ev);
    end
    if (idx >= 0) chkVc(tag, idx, vc);
    @(posedge clk);
    #1;
    tailDone  = '0;
    vcRelease = '0;
  endtask

  task automatic clearAll();
    tailDone  = '1;
    vcRelease = '1;
    cyc("cleanup", 20'h0, -1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int rrNext;
    int prevW, prevVc;
    rstN = 1'b0; reqValid = '0; reqPort = '0; tailDone = '0; vcRelease = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    cyc("R1 idle after reset", 20'h0, -1, 0);

    // R1 R2 R5 R6 R10: fill each port, block a fifth header, free one VC
    for (int p = 0; p < 5; p++) begin
      int i5;
      for (int k = 0; k < 4; k++) begin
        int i;
        i = (p + 4*k) % 20;
        setReq(i, p);
        cyc((k == 0) ? "R1 first grant VC0" : "R2 lowest free VC", 20'(1) << i, i, k);
        dropReq(i);
      end
      i5 = (p + 16) % 20;
      setReq(i5, p);
      cyc("R5 full port grants nothing", 20'h0, -1, 0);
      tailDone[(p + 4) % 20] = 1'b1;
      cyc("R6 tail alone keeps VC", 20'h0, -1, 0);
      cyc("R6 tail alone keeps VC later", 20'h0, -1, 0);
      vcRelease[p*4 + 1] = 1'b1;
      cyc("R10 release visible next cycle", 20'h0, -1, 0);
      cyc("R5 pending header granted", 20'(1) << i5, i5, 1);
      dropReq(i5);
      clearAll();
    end

    // R6: release before tail
    setReq(0, 0);
    cyc("R6 setup", 20'h1, 0, 0);
    dropReq(0);
    vcRelease[0] = 1'b1;
    cyc("R6 release only", 20'h0, -1, 0);
    setReq(1, 0);
    cyc("R6 release alone keeps VC", 20'h2, 1, 1);
    dropReq(1);
    tailDone[0] = 1'b1;
    cyc("R6 tail completes", 20'h0, -1, 0);
    setReq(2, 0);
    cyc("R6 VC0 free again", 20'h4, 2, 0);
    dropReq(2);
    clearAll();

    // R7: holder keeps requesting
    setReq(7, 1);
    cyc("R7 first grant", 20'h80, 7, 0);
    for (int n = 0; n < 3; n++) cyc("R7 holder not regranted", 20'h0, -1, 0);
    tailDone[7] = 1'b1;
    cyc("R7 tail cycle", 20'h0, -1, 0);
    cyc("R7 regrant after tail", 20'h80, 7, 1);
    dropReq(7);
    clearAll();

    // R8: illegal port codes
    for (int c = 5; c < 8; c++) begin
      setReq(3, c);
      cyc("R8 illegal port ignored", 20'h0, -1, 0);
    end
    setReq(3, 0);
    cyc("R8 no VC consumed", 20'h8, 3, 0);
    dropReq(3);
    clearAll();

    // R9: stray strobes
    vcRelease[12] = 1'b1;
    tailDone[9] = 1'b1;
    cyc("R9 stray strobes", 20'h0, -1, 0);
    setReq(9, 3);
    cyc("R9 grant after stray tail", 20'h200, 9, 0);
    dropReq(9);
    tailDone[9] = 1'b1;
    cyc("R9 tail only", 20'h0, -1, 0);
    setReq(10, 3);
    cyc("R9 early release was dropped", 20'h400, 10, 1);
    dropReq(10);
    clearAll();

    // R3 R4: two on port 4 (pointer at 1 after last winner 0), one on port 0
    setReq(4, 4); setReq(5, 4); setReq(6, 0);
    cyc("R3 one per port, ports independent", 20'h50, 4, 0);
    chkVc("R3 port 0 grant", 6, 0);
    dropReq(6);
    cyc("R4 next requester on port 4", 20'h20, 5, 1);
    dropReq(4); dropReq(5);
    clearAll();

    // R4: all twenty on port 2, recycling each VC one cycle after grant
    rrNext = 19;  // last winner on port 2 was input VC 18
    for (int i = 0; i < 20; i++) setReq(i, 2);
    prevW = -1; prevVc = 0;
    for (int n = 0; n < 40; n++) begin
      int w, v;
      w = (rrNext + n) % 20;
      v = (n == 0) ? 0 : (prevVc == 0 ? 1 : 0);
      if (prevW >= 0) begin
        tailDone[prevW] = 1'b1;
        vcRelease[8 + prevVc] = 1'b1;
      end
      cyc("R4 round-robin order", 20'(1) << w, w, v);
      prevW = w; prevVc = v;
    end
    reqValid = '0;
    clearAll();

    finishRun();
  end
endmodule